// File: doc/BRIEF.md
# Gamma Color Lookup Table

This block is the color correction stage of a display pipeline. It keeps one table per color channel (red, green, blue) and maps every incoming pixel channel code to a 14-bit output value. Software fills the tables through a small write port. A run is opened at a chosen start index, and each following write cycle delivers one 16-bit value per channel. Only the upper 14 bits of each value are kept.

A 2-bit depth code selects how the pixel path treats a code. At 8-bit depth, indexed pixels pass straight through. At 24-bit depth, or when no depth has been set yet, each code selects one table entry directly. At 30-bit depth, the ten-bit code is split into an entry index and a two-bit fraction, and the output is interpolated between two neighbouring entries. The top interval of that interpolation uses a 257th entry. This extra entry mirrors entry 255, and it is refreshed when the depth switches to 30 bits, so values loaded before any depth was known still take effect. The pixel path always takes two clock cycles.

Top module: `gamma_lut`

## Requirements
- R1: After reset, entry i of every channel holds i*64 (the 16-bit value i<<8 reduced to 14 bits), and the extra entry 256 holds 255*64. out_valid and all outputs are 0.
- R2: run_start loads the write index from run_index. Each wr_valid cycle stores bits 15:2 of each channel value at the current index, then advances the index by one. When run_start and wr_valid share a cycle, the write lands at run_index.
- R3: A run stops at index 256. Writes beyond index 255 are dropped, and the index does not wrap to 0.
- R4: out_valid and the channel outputs for a pixel appear exactly two rising edges after the edge that samples pix_valid.
- R5: With depth code 0 (no depth set) or 2 (24-bit), each output equals entry[code[9:2]] of its channel. Code bits 1:0 are ignored.
- R6: With depth code 1 (8-bit), each output equals code[9:2] shifted left by 6, whatever the table holds.
- R7: With depth code 3 (30-bit), each output equals e[k] + floor((e[k+1]-e[k])*f/4), with k = code[9:2] and f = code[1:0]. For k = 255, e[k+1] is the extra entry 256.
- R8: The extra entry 256 copies entry 255 on the cycle the depth code becomes 3 from any other code, including 0. While the depth code is 3, every write to index 255 also writes entry 256.
- R9: A pixel read and a table write to the same entry in the same cycle return the value held before the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| run_start | input | 1 | Opens a write run at run_index |
| run_index | input | 8 | Start index of a run |
| wr_valid | input | 1 | One table write at the current index |
| wr_red | input | 16 | Red write value |
| wr_green | input | 16 | Green write value |
| wr_blue | input | 16 | Blue write value |
| depth_mode | input | 2 | 0 unset, 1 8-bit bypass, 2 24-bit direct, 3 30-bit interpolated |
| pix_valid | input | 1 | Pixel present on the pixel inputs |
| pix_red | input | 10 | Red channel code |
| pix_green | input | 10 | Green channel code |
| pix_blue | input | 10 | Blue channel code |
| out_valid | output | 1 | Corrected pixel present |
| out_red | output | 14 | Corrected red |
| out_green | output | 14 | Corrected green |
| out_blue | output | 14 | Corrected blue |

## Verification
The bench sweeps every index in the direct and bypass modes and all 1024 codes in the interpolated mode, on each channel, with different table contents per channel. This catches a design that skips the precision cut, mixes up channels, or rounds the interpolation step instead of flooring it. It opens a run near the top of the table and then rereads the low entries, so an index that wraps past 255 shows up as corrupted early entries. It loads the top entry while no depth is set, and again while in the 30-bit mode, then probes code 1023. A design that never refreshes entry 256 would return a stale top interval there. A write and a read of the same entry in one cycle must return the old value, so a write-through path would be exposed.

// File: rtl/gamma_lut_pkg.sv
package gamma_lut_pkg;
  typedef enum logic [1:0] {
    DEPTH_NONE = 2'd0,
    DEPTH_8    = 2'd1,
    DEPTH_24   = 2'd2,
    DEPTH_30   = 2'd3
  } depth_e;
endpackage

// File: rtl/gamma_lut_wr_ctrl.sv
// Write index sequencer: opens runs, advances per write, parks at the end.
module gamma_lut_wr_ctrl #(
  parameter int IDX_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run_start,
  input  logic [IDX_W-1:0] run_index,
  input  logic             wr_valid,
  output logic             wr_en,
  output logic [IDX_W-1:0] wr_addr
);
  localparam int PTR_W = IDX_W + 1;

  logic [PTR_W-1:0] ptr_q, ptr_d, cur_idx;
  logic             ptr_en;

  always_comb begin
    cur_idx = run_start ? {1'b0, run_index} : ptr_q;
    wr_en   = wr_valid && !cur_idx[IDX_W];
    wr_addr = cur_idx[IDX_W-1:0];
    ptr_en  = run_start || wr_valid;
    ptr_d   = cur_idx + PTR_W'(wr_en);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      ptr_q <= '0;
    else if (ptr_en) ptr_q <= ptr_d;
  end
endmodule

// File: rtl/gamma_lut_chan.sv
// One channel table with its mirrored extra entry and the pixel read stage.
module gamma_lut_chan #(
  parameter int IDX_W = 8,
  parameter int IN_W  = 16,
  parameter int ST_W  = 14
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_addr,
  input  logic [IN_W-1:0]  wr_data,
  input  logic             at30,
  input  logic             load_ext,
  input  logic             rd_en,
  input  logic [IDX_W-1:0] rd_idx,
  output logic [ST_W-1:0]  lo_q,
  output logic [ST_W-1:0]  hi_q
);
  localparam int ENTRIES = 1 << IDX_W;
  localparam int DROP    = IN_W - ST_W;
  localparam int STEP_SH = IN_W - IDX_W;
  localparam logic [IDX_W-1:0] LAST = IDX_W'(ENTRIES - 1);
  localparam logic [ST_W-1:0]  EXT_RST = ST_W'(((ENTRIES - 1) << STEP_SH) >> DROP);

  logic [ENTRIES-1:0][ST_W-1:0] tbl;
  logic [ST_W-1:0]              wr_val, ext_q, ext_d, lo_d, hi_d;
  logic                         ext_en;
  logic [IDX_W-1:0]             nxt_idx;

  assign wr_val = wr_data[IN_W-1:DROP];

  for (genvar i = 0; i < ENTRIES; i++) begin : gen_ent
    localparam logic [ST_W-1:0] RST_V = ST_W'((i << STEP_SH) >> DROP);
    logic [ST_W-1:0] ent_q;
    logic            ent_we;
    assign ent_we = wr_en && (wr_addr == IDX_W'(i));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      ent_q <= RST_V;
      else if (ent_we) ent_q <= wr_val;
    end
    assign tbl[i] = ent_q;
  end

  always_comb begin
    ext_en = 1'b0;
    ext_d  = tbl[LAST];
    if (at30 && wr_en && wr_addr == LAST) begin
      ext_en = 1'b1;
      ext_d  = wr_val;
    end else if (load_ext) begin
      ext_en = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      ext_q <= EXT_RST;
    else if (ext_en) ext_q <= ext_d;
  end

  always_comb begin
    nxt_idx = rd_idx + 1'b1;
    lo_d    = tbl[rd_idx];
    hi_d    = (rd_idx == LAST) ? ext_q : tbl[nxt_idx];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lo_q <= '0;
      hi_q <= '0;
    end else if (rd_en) begin
      lo_q <= lo_d;
      hi_q <= hi_d;
    end
  end
endmodule

// File: rtl/gamma_lut_interp.sv
// Output stage: bypass, direct pick or fractional blend of two entries.
module gamma_lut_interp
  import gamma_lut_pkg::*;
#(
  parameter int IDX_W  = 8,
  parameter int ST_W   = 14,
  parameter int CODE_W = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  depth_e            mode,
  input  logic [CODE_W-1:0] code,
  input  logic [ST_W-1:0]   lo,
  input  logic [ST_W-1:0]   hi,
  output logic [ST_W-1:0]   res_q
);
  localparam int FRAC_W = CODE_W - IDX_W;
  localparam int DW     = ST_W + FRAC_W + 2;
  localparam int PAD    = ST_W - IDX_W;

  logic signed [DW-1:0] diff, prod, step;
  logic [ST_W-1:0]      blend, res_d;

  always_comb begin
    diff  = $signed({{(DW-ST_W){1'b0}}, hi}) - $signed({{(DW-ST_W){1'b0}}, lo});
    prod  = diff * $signed({{(DW-FRAC_W){1'b0}}, code[FRAC_W-1:0]});
    step  = prod >>> FRAC_W;
    blend = lo + step[ST_W-1:0];
    unique case (mode)
      DEPTH_8:  res_d = {code[CODE_W-1 -: IDX_W], {PAD{1'b0}}};
      DEPTH_30: res_d = blend;
      default:  res_d = lo;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  res_q <= '0;
    else if (en) res_q <= res_d;
  end
endmodule

// File: rtl/gamma_lut.sv
module gamma_lut
  import gamma_lut_pkg::*;
#(
  parameter int IDX_W  = 8,
  parameter int IN_W   = 16,
  parameter int ST_W   = 14,
  parameter int CODE_W = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run_start,
  input  logic [IDX_W-1:0]  run_index,
  input  logic              wr_valid,
  input  logic [IN_W-1:0]   wr_red,
  input  logic [IN_W-1:0]   wr_green,
  input  logic [IN_W-1:0]   wr_blue,
  input  logic [1:0]        depth_mode,
  input  logic              pix_valid,
  input  logic [CODE_W-1:0] pix_red,
  input  logic [CODE_W-1:0] pix_green,
  input  logic [CODE_W-1:0] pix_blue,
  output logic              out_valid,
  output logic [ST_W-1:0]   out_red,
  output logic [ST_W-1:0]   out_green,
  output logic [ST_W-1:0]   out_blue
);
  localparam int CH = 3;

  logic [CH-1:0][IN_W-1:0]   wr_bus;
  logic [CH-1:0][CODE_W-1:0] pix_bus, code1_q;
  logic [CH-1:0][ST_W-1:0]   lo_q, hi_q, res_q;
  logic                      wr_en, at30, load_ext, v1_q, vout_q;
  logic [IDX_W-1:0]          wr_addr;
  depth_e                    depth_cur, depth_prev_q, mode1_q;

  assign wr_bus    = {wr_blue, wr_green, wr_red};
  assign pix_bus   = {pix_blue, pix_green, pix_red};
  assign depth_cur = depth_e'(depth_mode);
  assign at30      = (depth_cur == DEPTH_30);
  assign load_ext  = at30 && (depth_prev_q != DEPTH_30);

  gamma_lut_wr_ctrl #(.IDX_W(IDX_W)) u_wr (
    .clk(clk), .rst_n(rst_n), .run_start(run_start), .run_index(run_index),
    .wr_valid(wr_valid), .wr_en(wr_en), .wr_addr(wr_addr)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      depth_prev_q <= DEPTH_NONE;
      v1_q         <= 1'b0;
      vout_q       <= 1'b0;
    end else begin
      depth_prev_q <= depth_cur;
      v1_q         <= pix_valid;
      vout_q       <= v1_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode1_q <= DEPTH_NONE;
      code1_q <= '0;
    end else if (pix_valid) begin
      mode1_q <= depth_cur;
      code1_q <= pix_bus;
    end
  end

  for (genvar c = 0; c < CH; c++) begin : gen_chan
    gamma_lut_chan #(.IDX_W(IDX_W), .IN_W(IN_W), .ST_W(ST_W)) u_chan (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
      .wr_data(wr_bus[c]), .at30(at30), .load_ext(load_ext),
      .rd_en(pix_valid), .rd_idx(pix_bus[c][CODE_W-1 -: IDX_W]),
      .lo_q(lo_q[c]), .hi_q(hi_q[c])
    );
    gamma_lut_interp #(.IDX_W(IDX_W), .ST_W(ST_W), .CODE_W(CODE_W)) u_interp (
      .clk(clk), .rst_n(rst_n), .en(v1_q), .mode(mode1_q), .code(code1_q[c]),
      .lo(lo_q[c]), .hi(hi_q[c]), .res_q(res_q[c])
    );
  end

  assign out_valid = vout_q;
  assign out_red   = res_q[0];
  assign out_green = res_q[1];
  assign out_blue  = res_q[2];
endmodule

// File: rtl/gamma_lut_chk.sv
module gamma_lut_chk #(
  parameter int IDX_W = 8,
  parameter int ST_W  = 14
) (
  input logic              clk,
  input logic              rst_n,
  input logic              pix_valid,
  input logic [1:0]        depth_mode,
  input logic              out_valid,
  input logic [ST_W-1:0]   out_red,
  input logic [ST_W-1:0]   out_green,
  input logic [ST_W-1:0]   out_blue,
  input logic [IDX_W:0]    ptr,
  input logic [1:0]        depth_prev,
  input logic [ST_W-1:0]   ext_red,
  input logic [ST_W-1:0]   top_red
);
  localparam int PAD = ST_W - IDX_W;
  localparam logic [IDX_W:0] END_IDX = (IDX_W + 1)'(1 << IDX_W);

  AST_LAT_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    pix_valid |-> ##2 out_valid); // R4
  AST_LAT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !pix_valid |-> ##2 !out_valid); // R4
  AST_BYPASS_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (pix_valid && depth_mode == 2'd1) |-> ##2
      (out_red[PAD-1:0] == '0 && out_green[PAD-1:0] == '0 && out_blue[PAD-1:0] == '0)); // R6
  AST_PTR_CLAMP: assert property (@(posedge clk) disable iff (!rst_n)
    ptr <= END_IDX); // R3
  AST_EXTRA_COPY: assert property (@(posedge clk) disable iff (!rst_n)
    (depth_prev == 2'd3) |-> (ext_red == top_red)); // R8
endmodule

bind gamma_lut gamma_lut_chk #(.IDX_W(IDX_W), .ST_W(ST_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .pix_valid(pix_valid), .depth_mode(depth_mode),
  .out_valid(out_valid), .out_red(out_red), .out_green(out_green), .out_blue(out_blue),
  .ptr(u_wr.ptr_q), .depth_prev(depth_prev_q),
  .ext_red(gen_chan[0].u_chan.ext_q), .top_red(gen_chan[0].u_chan.tbl[(1 << IDX_W) - 1])
);

// File: tb/gamma_lut_bench.sv
module gamma_lut_bench;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        run_start, wr_valid, pix_valid;
  logic [7:0]  run_index;
  logic [15:0] wr_red, wr_green, wr_blue;
  logic [1:0]  depth_mode;
  logic [9:0]  pix_red, pix_green, pix_blue;
  logic        out_valid;
  logic [13:0] out_red, out_green, out_blue;

  int mdl [3][257];
  int cur_depth;
  int n_chk = 0;
  int n_fail = 0;

  always #5 clk = ~clk;

  gamma_lut u_gamma_lut (
    .clk(clk), .rst_n(rst_n), .run_start(run_start), .run_index(run_index),
    .wr_valid(wr_valid), .wr_red(wr_red), .wr_green(wr_green), .wr_blue(wr_blue),
    .depth_mode(depth_mode), .pix_valid(pix_valid), .pix_red(pix_red),
    .pix_green(pix_green), .pix_blue(pix_blue), .out_valid(out_valid),
    .out_red(out_red), .out_green(out_green), .out_blue(out_blue)
  );

  task automatic check(string req, int got, int exp);
    n_chk++;
    if (got != exp) begin
      n_fail++;
      $display("FAIL %s actual %0d expected %0d", req, got, exp);
    end
  endtask

  function automatic int chan_code(int c, int code);
    if (c == 0) return code & 1023;
    if (c == 1) return (code * 5 + 3) & 1023;
    return 1023 - (code & 1023);
  endfunction

  function automatic int pattern(int seed, int c, int k);
    return (seed * 7919 + k * 1237 + c * 4099 + 17) & 16'hFFFF;
  endfunction

  function automatic int expect_val(int c, int code, int d);
    int k = code >> 2;
    int f = code & 3;
    if (d == 1) return k << 6;
    if (d == 3) return mdl[c][k] + (((mdl[c][k+1] - mdl[c][k]) * f) >>> 2);
    return mdl[c][k];
  endfunction

  task automatic set_depth(int d);
    @(negedge clk);
    depth_mode = 2'(d);
    if (d == 3 && cur_depth != 3)
      for (int c = 0; c < 3; c++) mdl[c][256] = mdl[c][255];
    cur_depth = d;
    @(posedge clk);
  endtask

  task automatic write_run(int start, int n, int seed);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      run_start = (k == 0);
      run_index = 8'(start);
      wr_valid  = 1'b1;
      wr_red    = 16'(pattern(seed, 0, k));
      wr_green  = 16'(pattern(seed, 1, k));
      wr_blue   = 16'(pattern(seed, 2, k));
      if (start + k < 256)
        for (int c = 0; c < 3; c++) begin
          mdl[c][start+k] = pattern(seed, c, k) >> 2;
          if (start + k == 255 && cur_depth == 3) mdl[c][256] = mdl[c][255];
        end
    end
    @(negedge clk);
    run_start = 1'b0;
    wr_valid  = 1'b0;
  endtask

  task automatic pixel(int code, string req);
    @(negedge clk);
    pix_valid = 1'b1;
    pix_red   = 10'(chan_code(0, code));
    pix_green = 10'(chan_code(1, code));
    pix_blue  = 10'(chan_code(2, code));
    @(negedge clk);
    pix_valid = 1'b0;
    @(posedge clk);
    #1;
    check({req, " valid"}, int'(out_valid), 1);
    check({req, " red"},   int'(out_red),   expect_val(0, chan_code(0, code), cur_depth));
    check({req, " green"}, int'(out_green), expect_val(1, chan_code(1, code), cur_depth));
    check({req, " blue"},  int'(out_blue),  expect_val(2, chan_code(2, code), cur_depth));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog (all R) actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    rst_n = 1'b0; run_start = 1'b0; wr_valid = 1'b0; pix_valid = 1'b0;
    run_index = '0; wr_red = '0; wr_green = '0; wr_blue = '0;
    depth_mode = 2'd0; pix_red = '0; pix_green = '0; pix_blue = '0;
    cur_depth = 0;
    for (int i = 0; i < 256; i++)
      for (int c = 0; c < 3; c++) mdl[c][i] = i * 64;
    for (int c = 0; c < 3; c++) mdl[c][256] = 255 * 64;
    repeat (3) @(posedge clk);
    #1;
    // R1: outputs idle in reset
    check("R1 reset valid", int'(out_valid), 0);
    check("R1 reset red", int'(out_red), 0);
    check("R1 reset blue", int'(out_blue), 0);
    @(negedge clk);
    rst_n = 1'b1;

    // R1 / R5: identity ramp read through direct lookup
    set_depth(2);
    for (int i = 0; i < 256; i++) pixel(i * 4 + (i & 3), "R1_R5 ramp");
    // R1 / R7: ramp interpolation including the extra entry at reset
    set_depth(3);
    for (int i = 0; i < 1024; i++) pixel(i, "R1_R7 ramp blend");

    // R2 / R5: full load at 24-bit depth
    set_depth(2);
    write_run(0, 256, 1);
    for (int i = 0; i < 256; i++) pixel(i * 4 + 3, "R2_R5 full load");
    // R8: entering 30-bit copies the new entry 255; R7 sweep
    set_depth(3);
    for (int i = 0; i < 1024; i++) pixel(i, "R7_R8 blend sweep");

    // R8: loaded while depth unset, then switch into 30-bit
    set_depth(0);
    write_run(200, 56, 2);
    for (int i = 200; i < 256; i++) pixel(i * 4 + 2, "R5 unset depth");
    set_depth(3);
    pixel(1023, "R8 unset then 30");
    pixel(1021, "R8 unset then 30");
    // R8: write to 255 while at 30-bit
    write_run(255, 1, 3);
    pixel(1023, "R8 write top at 30");
    pixel(1022, "R8 write top at 30");

    // R3: run past the end, no wrap
    write_run(250, 12, 4);
    pixel(1023, "R3_R8 clamp top");
    set_depth(2);
    for (int i = 0; i < 256; i++) pixel(i * 4 + 1, "R3 clamp no wrap");
    // R2: a new run after the parked index still writes
    write_run(10, 4, 5);
    for (int i = 8; i < 16; i++) pixel(i * 4, "R2 second run");

    // R6: bypass ignores the table
    set_depth(1);
    for (int i = 0; i < 256; i++) pixel(i * 4 + (i & 3), "R6 bypass");

    // R9: write and read of entry 100 in one cycle
    set_depth(2);
    @(negedge clk);
    run_start = 1'b1; run_index = 8'd100; wr_valid = 1'b1;
    wr_red = 16'hABCD; wr_green = 16'h1234; wr_blue = 16'hFFFF;
    pix_valid = 1'b1;
    pix_red   = 10'(chan_code(0, 400));
    pix_green = 10'(chan_code(1, 400));
    pix_blue  = 10'(chan_code(2, 400));
    @(negedge clk);
    run_start = 1'b0; wr_valid = 1'b0; pix_valid = 1'b0;
    @(posedge clk);
    #1;
    check("R9 collision red old", int'(out_red), mdl[0][100]);
    mdl[0][100] = 16'hABCD >> 2;
    mdl[1][100] = 16'h1234 >> 2;
    mdl[2][100] = 16'hFFFF >> 2;
    pixel(400, "R9 after collision");

    // R4: valid drops two cycles after the last pixel
    @(negedge clk);
    @(posedge clk);
    #1;
    check("R4 idle valid", int'(out_valid), 0);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule